// File: doc/BRIEF.md
# Resonant Lamp Half-Bridge Drive Sequencer

This block drives the two gates of a half bridge that feeds a series-resonant lamp circuit, and it steps the switching frequency through the phases a fluorescent lamp needs. When enabled, it first runs at a high frequency, well above resonance, so that the filaments warm up. It then sweeps the frequency down toward the ignition point one step per phase tick and waits for the lamp to strike. Once the lamp runs, it holds its frequency and raises it when the lamp current sags. On an overcurrent, or when the lamp fails to strike, it restarts with its own restart settings. After a bounded number of restarts it stops the bridge and asks for a supply shutdown.

Frequency is set by a programmable period count in clock cycles. The high-side and low-side gates each take one half of the period, less a dead-time gap, so they are never on together. A new period count is only adopted when the current period has finished, so the sweep never produces a clipped pulse. Lamp current sensing and the tank itself lie outside the block: it sees only three status flags and a slow tick that paces its phases.

Top module: `ballast_hb_seq`

## Requirements
- R1: With period count P (P even, default settings), gate_hi_o is high for P/2 - DEAD_CYC cycles starting at count 0, gate_lo_o is high for P/2 - DEAD_CYC cycles starting at count P/2, each gate rises once every P cycles, and the two gates are never high in the same cycle.
- R2: While enable_i is low, run_o and shutdown_o are low from the next clock, and both gates and freq_code_o are zero within three clocks.
- R3: After enable_i rises, the bridge runs with period P_PREHEAT (default 40) and keeps it for PREHEAT_TICKS (default 4) ticks; freq_code_o reports the period count in use.
- R4: After preheat, each tick raises the period by P_STEP (default 8), saturating at P_IGNITE (default 72), so the frequency never rises during the sweep.
- R5: During the sweep, ign_ok_i high puts the block in run mode, shown by run_o high.
- R6: A tick during the sweep while the period is already P_IGNITE and no ignition was seen is a failure: the period becomes P_RESTART (default 48), held for RESTART_TICKS (default 2) ticks, after which the sweep resumes from that period.
- R7: In run mode, a tick with cur_low_i high shortens the period by P_STEP, never below P_PREHEAT; a tick with cur_low_i low leaves the period unchanged.
- R8: In run mode, over_cur_i high is a failure: run_o drops and the restart phase of R6 begins.
- R9: Failures are counted and the count clears only while enable_i is low; a failure that occurs after MAX_RETRY (default 6) earlier ones raises shutdown_o and holds both gates low, ignoring ticks and status flags, until enable_i goes low.
- R10: A new period count takes effect only after the current period completes, so every gate pulse has the full width for the period it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Run request; low returns to idle and clears the failure count |
| tick_i | input | 1 | Single-cycle phase timer pulse |
| ign_ok_i | input | 1 | Lamp ignition detected |
| cur_low_i | input | 1 | Lamp current below its reduced-load threshold |
| over_cur_i | input | 1 | Lamp overcurrent |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_lo_o | output | 1 | Low-side gate drive |
| freq_code_o | output | PER_W | Period count in use, in clocks; zero while the bridge is off |
| run_o | output | 1 | Lamp in run mode |
| shutdown_o | output | 1 | Retries exhausted; bridge stopped and supply shutdown requested |

## Verification
A wrong sequencer state appears on freq_code_o at the next period boundary, at most one period (under 80 clocks) after the tick that should have moved it, and on run_o or shutdown_o one clock after the triggering flag. A wrong period counter or a period loaded mid-cycle appears as a gate pulse whose width or spacing disagrees with the period reported for it. A miscounted failure shows as shutdown_o rising one restart early or late. Gate overlap would be visible in the very cycle it happens.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PREHEAT  = 3'd1,
    ST_SWEEP    = 3'd2,
    ST_RUN      = 3'd3,
    ST_RESTART  = 3'd4,
    ST_SHUTDOWN = 3'd5
  } seq_state_e;

endpackage

// File: rtl/hb_pwm.sv
// Period counter and complementary gate generator with dead time.
module hb_pwm #(
  parameter int PER_W    = 12,
  parameter int DEAD_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] tgt_per_i,
  output logic             gate_hi_o,
  output logic             gate_lo_o,
  output logic [PER_W-1:0] cur_per_o,
  output logic             wrap_o
);

  localparam logic [PER_W-1:0] DEAD_V = PER_W'(DEAD_CYC);
  localparam logic [PER_W-1:0] ONE_V  = PER_W'(1);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] half_d;
  logic             hi_q, hi_d;
  logic             lo_q, lo_d;
  logic             wrap_c;

  // end of the current period; only meaningful while driving
  assign wrap_c = en_i && (cnt_q == per_q - ONE_V);

  always_comb begin
    if (!en_i) begin
      // parked on the last count so the first enabled cycle is a boundary
      per_d = tgt_per_i;
      cnt_d = tgt_per_i - ONE_V;
    end else if (wrap_c) begin
      per_d = tgt_per_i;
      cnt_d = '0;
    end else begin
      per_d = per_q;
      cnt_d = cnt_q + ONE_V;
    end
    half_d = per_d >> 1;
    hi_d   = en_i && (cnt_d < (half_d - DEAD_V));
    lo_d   = en_i && (cnt_d >= half_d) && (cnt_d < (per_d - DEAD_V));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;
  assign cur_per_o = per_q;
  assign wrap_o    = wrap_c;

endmodule

// File: rtl/bal_seq_fsm.sv
// Phase sequencer: preheat, sweep, run, restart, shutdown.
module bal_seq_fsm
  import ballast_pkg::*;
#(
  parameter int PER_W         = 12,
  parameter int P_PREHEAT     = 40,
  parameter int P_IGNITE      = 72,
  parameter int P_RESTART     = 48,
  parameter int P_STEP        = 8,
  parameter int PREHEAT_TICKS = 4,
  parameter int RESTART_TICKS = 2,
  parameter int MAX_RETRY     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             ign_i,
  input  logic             low_i,
  input  logic             oc_i,
  output seq_state_e       state_o,
  output logic [PER_W-1:0] tgt_per_o,
  output logic             drive_en_o
);

  localparam int MAXT = (PREHEAT_TICKS > RESTART_TICKS) ? PREHEAT_TICKS : RESTART_TICKS;
  localparam int PH_W = $clog2(MAXT + 1);
  localparam int RT_W = $clog2(MAX_RETRY + 1);

  localparam logic [PER_W-1:0] PRE_V = PER_W'(P_PREHEAT);
  localparam logic [PER_W-1:0] IGN_V = PER_W'(P_IGNITE);
  localparam logic [PER_W-1:0] RST_V = PER_W'(P_RESTART);
  localparam logic [PER_W:0]   STP_X = (PER_W+1)'(P_STEP);
  localparam logic [PER_W:0]   IGN_X = (PER_W+1)'(P_IGNITE);
  localparam logic [PER_W:0]   LOW_X = (PER_W+1)'(P_PREHEAT + P_STEP);
  localparam logic [PH_W-1:0]  PRE_LAST = PH_W'(PREHEAT_TICKS - 1);
  localparam logic [PH_W-1:0]  RST_LAST = PH_W'(RESTART_TICKS - 1);
  localparam logic [RT_W-1:0]  RT_MAX   = RT_W'(MAX_RETRY);

  seq_state_e       state_q, state_d;
  logic [PER_W-1:0] tgt_q, tgt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [RT_W-1:0]  rt_q, rt_d;
  logic             fail_c;
  logic [PER_W:0]   up_sum;
  logic [PH_W-1:0]  ph_last;

  assign up_sum  = {1'b0, tgt_q} + STP_X;
  assign ph_last = (state_q == ST_PREHEAT) ? PRE_LAST : RST_LAST;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    ph_d    = ph_q;
    rt_d    = rt_q;
    fail_c  = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
      tgt_d   = PRE_V;
      ph_d    = '0;
      rt_d    = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_PREHEAT;
          tgt_d   = PRE_V;
          ph_d    = '0;
        end
        ST_PREHEAT, ST_RESTART: begin
          if (tick_i) begin
            if (ph_q == ph_last) begin
              state_d = ST_SWEEP;
              ph_d    = '0;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
        end
        ST_SWEEP: begin
          if (ign_i) begin
            state_d = ST_RUN;
          end else if (tick_i) begin
            if (tgt_q >= IGN_V) begin
              fail_c = 1'b1;
            end else if (up_sum >= IGN_X) begin
              tgt_d = IGN_V;
            end else begin
              tgt_d = up_sum[PER_W-1:0];
            end
          end
        end
        ST_RUN: begin
          if (oc_i) begin
            fail_c = 1'b1;
          end else if (tick_i && low_i) begin
            if ({1'b0, tgt_q} <= LOW_X) tgt_d = PRE_V;
            else                        tgt_d = tgt_q - STP_X[PER_W-1:0];
          end
        end
        ST_SHUTDOWN: begin
          state_d = ST_SHUTDOWN;
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
      if (fail_c) begin
        if (rt_q == RT_MAX) begin
          state_d = ST_SHUTDOWN;
        end else begin
          rt_d    = rt_q + 1'b1;
          state_d = ST_RESTART;
          tgt_d   = RST_V;
          ph_d    = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= PRE_V;
      ph_q    <= '0;
      rt_q    <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      ph_q    <= ph_d;
      rt_q    <= rt_d;
    end
  end

  assign state_o    = state_q;
  assign tgt_per_o  = tgt_q;
  assign drive_en_o = (state_q == ST_PREHEAT) || (state_q == ST_SWEEP) ||
                      (state_q == ST_RUN)     || (state_q == ST_RESTART);

endmodule

// File: rtl/ballast_hb_seq.sv
module ballast_hb_seq
  import ballast_pkg::*;
#(
  parameter int PER_W         = 12,
  parameter int DEAD_CYC      = 3,
  parameter int P_PREHEAT     = 40,
  parameter int P_IGNITE      = 72,
  parameter int P_RESTART     = 48,
  parameter int P_STEP        = 8,
  parameter int PREHEAT_TICKS = 4,
  parameter int RESTART_TICKS = 2,
  parameter int MAX_RETRY     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             ign_ok_i,
  input  logic             cur_low_i,
  input  logic             over_cur_i,
  output logic             gate_hi_o,
  output logic             gate_lo_o,
  output logic [PER_W-1:0] freq_code_o,
  output logic             run_o,
  output logic             shutdown_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  seq_state_e       seq_state;
  logic [PER_W-1:0] tgt_per;
  logic [PER_W-1:0] cur_per;
  logic             drive_en;
  logic             pwm_wrap;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bal_seq_fsm #(
    .PER_W(PER_W), .P_PREHEAT(P_PREHEAT), .P_IGNITE(P_IGNITE),
    .P_RESTART(P_RESTART), .P_STEP(P_STEP), .PREHEAT_TICKS(PREHEAT_TICKS),
    .RESTART_TICKS(RESTART_TICKS), .MAX_RETRY(MAX_RETRY)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .enable_i   (enable_i),
    .tick_i     (tick_i),
    .ign_i      (ign_ok_i),
    .low_i      (cur_low_i),
    .oc_i       (over_cur_i),
    .state_o    (seq_state),
    .tgt_per_o  (tgt_per),
    .drive_en_o (drive_en)
  );

  hb_pwm #(
    .PER_W(PER_W), .DEAD_CYC(DEAD_CYC)
  ) u_pwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (drive_en),
    .tgt_per_i (tgt_per),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o),
    .cur_per_o (cur_per),
    .wrap_o    (pwm_wrap)
  );

  assign freq_code_o = drive_en ? cur_per : '0;
  assign run_o       = (seq_state == ST_RUN);
  assign shutdown_o  = (seq_state == ST_SHUTDOWN);

endmodule

// File: rtl/ballast_hb_seq_chk.sv
module ballast_hb_seq_chk
  import ballast_pkg::*;
#(
  parameter int PER_W = 12
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             enable_i,
  input logic             ign_ok_i,
  input logic             gate_hi_o,
  input logic             gate_lo_o,
  input logic [PER_W-1:0] freq_code_o,
  input logic             run_o,
  input logic             shutdown_o,
  input logic             drive_en,
  input logic             pwm_wrap,
  input seq_state_e       seq_state,
  input logic [PER_W-1:0] tgt_per
);

  assert_gate_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(gate_hi_o && gate_lo_o));

  assert_idle_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable_i |=> (!run_o && !shutdown_o));

  assert_sweep_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (seq_state == ST_SWEEP && $past(seq_state) == ST_SWEEP) |-> (tgt_per >= $past(tgt_per)));

  assert_run_needs_ignite_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(run_o) |-> $past(ign_ok_i));

  assert_shutdown_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shutdown_o && $past(shutdown_o)) |-> (!gate_hi_o && !gate_lo_o));

  assert_period_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (drive_en && $past(drive_en) && (freq_code_o != $past(freq_code_o))) |-> $past(pwm_wrap));

endmodule

bind ballast_hb_seq ballast_hb_seq_chk #(.PER_W(PER_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .ign_ok_i    (ign_ok_i),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o),
  .freq_code_o (freq_code_o),
  .run_o       (run_o),
  .shutdown_o  (shutdown_o),
  .drive_en    (drive_en),
  .pwm_wrap    (pwm_wrap),
  .seq_state   (seq_state),
  .tgt_per     (tgt_per)
);

// File: tb/ballast_hb_seq_tb.sv
`timescale 1ns/1ps
module ballast_hb_seq_tb;

  localparam int PER_W = 12;
  localparam int DEAD  = 3;
  localparam int WAITC = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, tick = 1'b0, ign = 1'b0, low = 1'b0, oc = 1'b0;
  logic gate_hi, gate_lo, run, shutdown;
  logic [PER_W-1:0] freq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int overlap_err = 0, width_err = 0, period_err = 0, widths_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ballast_hb_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .tick_i(tick),
    .ign_ok_i(ign), .cur_low_i(low), .over_cur_i(oc),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .freq_code_o(freq),
    .run_o(run), .shutdown_o(shutdown)
  );

  // pulse width / spacing monitor, sampled on falling edges
  logic prev_hi = 0, prev_lo = 0, prev_valid = 0;
  int hi_len = 0, lo_len = 0, since_rise = 0, hi_per = 0, lo_per = 0, rise_per = 0;
  always @(negedge clk) begin
    cyc++;
    if (gate_hi && gate_lo) overlap_err++;
    if (freq == 0) prev_valid = 0;
    since_rise++;
    if (gate_hi && !prev_hi) begin
      if (prev_valid && freq != 0 && since_rise != rise_per) period_err++;
      prev_valid = (freq != 0);
      rise_per = freq; since_rise = 0; hi_per = freq; hi_len = 0;
    end
    if (gate_lo && !prev_lo) begin lo_per = freq; lo_len = 0; end
    if (gate_hi) hi_len++;
    if (gate_lo) lo_len++;
    if (!gate_hi && prev_hi && freq != 0) begin
      widths_seen++;
      if (hi_len != hi_per / 2 - DEAD) width_err++;
    end
    if (!gate_lo && prev_lo && freq != 0) begin
      widths_seen++;
      if (lo_len != lo_per - lo_per / 2 - DEAD) width_err++;
    end
    prev_hi = gate_hi; prev_lo = gate_lo;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic tick_wait();
    pulse_tick();
    cycles(WAITC);
  endtask

  task automatic t_reset();
    cycles(3);
    check("R2 reset gate_hi", gate_hi, 0);
    check("R2 reset gate_lo", gate_lo, 0);
    check("R2 reset freq_code", freq, 0);
    check("R2 reset run", run, 0);
    check("R2 reset shutdown", shutdown, 0);
  endtask

  task automatic t_preheat_sweep();
    int exp;
    enable = 1'b1;
    cycles(WAITC);
    check("R3 preheat period", freq, 40);
    for (int i = 0; i < 4; i++) tick_wait();
    check("R3 period after preheat ticks", freq, 40);
    check("R5 no run before ignition", run, 0);
    exp = 40;
    for (int i = 0; i < 4; i++) begin
      tick_wait();
      exp = exp + 8;
      check("R4 sweep step", freq, exp);
    end
    @(negedge clk); ign = 1'b1;
    @(negedge clk); ign = 1'b0;
    cycles(2);
    check("R5 run after ignition", run, 1);
    cycles(WAITC);
    check("R5 period held at ignition", freq, 72);
  endtask

  task automatic t_run_low();
    low = 1'b1;
    tick_wait();
    check("R7 low current raises frequency", freq, 64);
    for (int i = 0; i < 5; i++) tick_wait();
    check("R7 floor at preheat period", freq, 40);
    low = 1'b0;
    tick_wait();
    tick_wait();
    check("R7 no step without low current", freq, 40);
    check("R7 still running", run, 1);
  endtask

  task automatic t_overcurrent();
    @(negedge clk); oc = 1'b1;
    @(negedge clk); oc = 1'b0;
    cycles(2);
    check("R8 run drops on overcurrent", run, 0);
    cycles(WAITC);
    check("R8 restart period", freq, 48);
    tick_wait();
    tick_wait();
    check("R6 restart hold", freq, 48);
    tick_wait();
    check("R6 sweep resumes from restart", freq, 56);
    @(negedge clk); ign = 1'b1;
    @(negedge clk); ign = 1'b0;
    cycles(2);
    check("R5 run after re-ignition", run, 1);
  endtask

  task automatic t_disable();
    @(negedge clk); enable = 1'b0;
    cycles(3);
    check("R2 disable gate_hi", gate_hi, 0);
    check("R2 disable gate_lo", gate_lo, 0);
    check("R2 disable freq_code", freq, 0);
    check("R2 disable run", run, 0);
    cycles(10);
  endtask

  task automatic t_retry_shutdown();
    int hi_seen;
    enable = 1'b1;
    cycles(WAITC);
    for (int i = 0; i < 8; i++) tick_wait();
    check("R6 reached ignition period", freq, 72);
    tick_wait();
    check("R6 failed ignition restarts", freq, 48);
    check("R9 no shutdown after first failure", shutdown, 0);
    for (int k = 1; k <= 6; k++) begin
      for (int i = 0; i < 5; i++) tick_wait();
      if (k == 1) check("R6 restart sweep tops out", freq, 72);
      tick_wait();
      check("R9 shutdown only after retries used", shutdown, (k == 6) ? 1 : 0);
    end
    @(negedge clk); ign = 1'b1; tick = 1'b1;
    @(negedge clk); ign = 1'b0; tick = 1'b0;
    hi_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (gate_hi || gate_lo) hi_seen++;
    end
    check("R9 gates quiet in shutdown", hi_seen, 0);
    check("R9 ignition ignored in shutdown", run, 0);
    check("R9 shutdown held", shutdown, 1);
    check("R9 freq_code zero in shutdown", freq, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); enable = 1'b0;
    cycles(2);
    check("R9 shutdown cleared by disable", shutdown, 0);
    @(negedge clk); enable = 1'b1;
    cycles(WAITC);
    check("R3 fresh start at preheat period", freq, 40);
    for (int i = 0; i < 8; i++) tick_wait();
    tick_wait();
    check("R9 count cleared, failure restarts", shutdown, 0);
    check("R9 restart period after clear", freq, 48);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cycles(5);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_preheat_sweep();
    t_run_low();
    t_overcurrent();
    t_disable();
    t_retry_shutdown();
    t_clear();
    check("R1 gate overlap count", overlap_err, 0);
    check("R10 gate pulse widths", width_err, 0);
    check("R1 gate period spacing", period_err, 0);
    check("R1 pulses observed", (widths_seen > 100) ? 1 : 0, 1);
    done = 1;
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

endmodule